// File: doc/BRIEF.md
# Multi-Channel Event Timestamp Recorder

This block timestamps digital events. It watches 31 event inputs and keeps a free-running time counter that advances once for each pulse on a one-microsecond tick-enable input. On a tick where at least one input has gone from low to high, the block writes a two-word record into an internal word buffer. The first word is the counter value. The second word is a bitmap that marks which channels rose on that tick. Bit 31 of the bitmap is reserved as an overflow error flag.

A setup input selects one event channel as the repetition marker. A rising edge on that channel restarts the time base at zero. When the buffer cannot take a whole record, that record is discarded and the overflow is remembered. A run-time mode input selects the response to an overflow: the block either keeps going or halts until the next start command. The buffer is drained through a simple show-ahead read port. Anything that moves the data further belongs to the surrounding system.

Top module: `evt_stamp_rec`

## Requirements
- R1: While the block is idle (after reset, before the first `start_i` pulse), the timer holds zero. Each tick afterwards moves it forward by one. The time word of a record is the timer value after that tick has been applied, so the first tick after start stamps 1.
- R2: When the timer is at its all-ones value, the next tick wraps it to zero and counting continues.
- R3: Each input passes through two synchronizing flops. A channel counts as having an event on a tick only if its synchronized level is high and its level on the previous tick was low. A level held high, or a fall, produces no event.
- R4: A tick with at least one event writes exactly two words on consecutive clocks: the time word first, then the bitmap word. Bit i of the bitmap (i = 0..30) is set when channel i had an event, and bit 31 is the error flag. A tick with no event writes nothing.
- R5: A rising edge on the channel selected by `rep_sel_i` (0..30) sets the timer to zero on that tick. The record made on that tick therefore carries time 0, and the edge is still logged in the bitmap. A select value of 31 disables the repetition reset.
- R6: A record is written only when at least two buffer words are free. Otherwise the whole record is dropped, `ovf_pend_o` goes high, and the buffer is never written past full.
- R7: With `ovf_halt_i` = 0, the block stays running after an overflow. The first record written afterwards has bitmap bit 31 set, and `ovf_pend_o` then clears.
- R8: With `ovf_halt_i` = 1, an overflow moves the block to a halted state (`halted_o` = 1, `running_o` = 0). While halted, events write nothing even if space is free. A `start_i` pulse resumes recording, and the first record after that has bit 31 set.
- R9: `rd_data_o` always shows the oldest stored word. A `rd_en_i` pulse while not empty removes that word. `empty_o` and `level_o` report the stored word count.
- R10: No record is written while idle. Edges seen while idle are absorbed and not logged later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | One-clock time-base pulse, at least three clocks apart |
| start_i | input | 1 | Start command; also resumes from halt |
| ovf_halt_i | input | 1 | Overflow policy: 1 halts, 0 discards and continues |
| rep_sel_i | input | 5 | Repetition channel number; 31 disables |
| ch_i | input | 31 | Asynchronous event inputs |
| rd_en_i | input | 1 | Pop the oldest buffer word |
| rd_data_o | output | 32 | Oldest buffer word (show-ahead) |
| empty_o | output | 1 | Buffer holds no words |
| level_o | output | clog2(DEPTH+1) | Words stored |
| running_o | output | 1 | Recording is active |
| halted_o | output | 1 | Stopped after an overflow in halt mode |
| ovf_pend_o | output | 1 | An overflow is waiting to be flagged in a record |

## Verification
A table of channel patterns checks the edge detector against each pattern type:
- isolated single-bit rises;
- a level held high, which separates edge from level detection;
- a fall, which must log nothing;
- overlapping rises, where only the new bits may appear;
- alternating and near-full masks that include the repetition channel, which show that the timer reset and the logging of that same edge both happen.

Directed runs cover the remaining cases:
- ticks before start, which separate the idle hold from the running state;
- a long quiet stretch that forces the timer to wrap;
- filling the buffer under each overflow mode, which shows whether the block drops the record, halts, or flags the next record written.

// File: rtl/esr_pkg.sv
// Package: shared constants and state types for the event timestamp recorder.
// Assumes a 32-bit record word; the top bitmap bit is reserved for errors.
package esr_pkg;
    localparam int WORD_W = 32;
    localparam int EV_CH  = WORD_W - 1;
    localparam int SEL_W  = $clog2(WORD_W);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HALT = 2'd2
    } run_state_t;

    typedef enum logic [1:0] {
        PH_NONE = 2'd0,
        PH_TIME = 2'd1,
        PH_MAP  = 2'd2
    } wr_phase_t;
endpackage

// File: rtl/esr_sync.sv
// Module: two-flop synchronizer for a vector of asynchronous inputs.
// Assumes each bit is an independent level; no multi-bit coherence is implied.
module esr_sync #(
    parameter int W = 31
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    // Two register stages to settle asynchronous inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= d_i;
            sync_q <= meta_q;
        end
    end

    assign q_o = sync_q;
endmodule

// File: rtl/esr_timer.sv
// Module: tick-driven time counter with hold and synchronous clear.
// Assumes clr_i matters only on a tick; wraps naturally past all-ones.
module esr_timer #(
    parameter int TS_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick_i,
    input  logic            hold_i,
    input  logic            clr_i,
    output logic [TS_W-1:0] count_o
);
    logic [TS_W-1:0] count_q;

    // Hold at zero while idle, otherwise count or clear on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n || hold_i) begin
            count_q <= '0;
        end else if (tick_i) begin
            if (clr_i) count_q <= '0;
            else       count_q <= count_q + 1'b1;
        end
    end

    assign count_o = count_q;

    p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !hold_i && !clr_i && count_q == {TS_W{1'b1}}) |=> (count_q == '0))
        else $error("timer did not wrap to zero");
endmodule

// File: rtl/esr_fifo.sv
// Module: word buffer with show-ahead read and a fill level.
// Assumes DEPTH is a power of two and the writer never writes when full.
module esr_fifo #(
    parameter int DEPTH = 64,
    parameter int W     = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en_i,
    input  logic [W-1:0]               wr_data_i,
    input  logic                       rd_en_i,
    output logic [W-1:0]               rd_data_o,
    output logic                       empty_o,
    output logic [$clog2(DEPTH+1)-1:0] level_o
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int LVL_W = $clog2(DEPTH + 1);

    logic [W-1:0]     mem_q [DEPTH];
    logic [PTR_W-1:0] wptr_q;
    logic [PTR_W-1:0] rptr_q;
    logic [LVL_W-1:0] level_q;
    logic             do_rd;
    logic             full;

    assign full  = (level_q == LVL_W'(DEPTH));
    assign do_rd = rd_en_i && (level_q != '0);

    // Store incoming words.
    always_ff @(posedge clk) begin
        if (wr_en_i) mem_q[wptr_q] <= wr_data_i;
    end

    // Advance pointers and track the fill level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr_q  <= '0;
            rptr_q  <= '0;
            level_q <= '0;
        end else begin
            if (wr_en_i) wptr_q <= wptr_q + 1'b1;
            if (do_rd)   rptr_q <= rptr_q + 1'b1;
            level_q <= level_q + LVL_W'(wr_en_i) - LVL_W'(do_rd);
        end
    end

    assign rd_data_o = mem_q[rptr_q];
    assign empty_o   = (level_q == '0);
    assign level_o   = level_q;

    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |-> !full)
        else $error("write into full buffer");

    p_level_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        level_q <= LVL_W'(DEPTH))
        else $error("level above depth");
endmodule

// File: rtl/evt_stamp_rec.sv
// Module: multi-channel event timestamp recorder (top).
// Synchronizes inputs, detects rising edges on each tick, and writes
// {time, bitmap} records into the buffer. It also handles repetition
// resets and overflow policy.
// Assumes tick_i pulses are at least three clocks apart, so a record's
// two writes finish before the next tick.
module evt_stamp_rec #(
    parameter int DEPTH = 64,
    parameter int TS_W  = 32
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             tick_i,
    input  logic                             start_i,
    input  logic                             ovf_halt_i,
    input  logic [$clog2(esr_pkg::WORD_W)-1:0] rep_sel_i,
    input  logic [esr_pkg::WORD_W-2:0]       ch_i,
    input  logic                             rd_en_i,
    output logic [esr_pkg::WORD_W-1:0]       rd_data_o,
    output logic                             empty_o,
    output logic [$clog2(DEPTH+1)-1:0]       level_o,
    output logic                             running_o,
    output logic                             halted_o,
    output logic                             ovf_pend_o
);
    import esr_pkg::*;

    localparam int LVL_W = $clog2(DEPTH + 1);

    logic [EV_CH-1:0]  ch_s;
    logic [EV_CH-1:0]  prev_q;
    logic [EV_CH-1:0]  rise;
    logic              any_rise;
    logic              rep_hit;
    logic              room;
    logic [TS_W-1:0]   tmr_cnt;
    run_state_t        state_q;
    wr_phase_t         phase_q;
    logic [WORD_W-1:0] map_q;
    logic              ovf_q;
    logic              buf_wr;
    logic [WORD_W-1:0] buf_wdata;
    logic              accept;

    esr_sync #(.W(EV_CH)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (ch_i),
        .q_o   (ch_s)
    );

    // Rising edges since the previous tick.
    assign rise     = ch_s & ~prev_q;
    assign any_rise = |rise;

    // Select the repetition channel's edge; out-of-range select disables it.
    always_comb begin
        rep_hit = 1'b0;
        for (int i = 0; i < EV_CH; i++) begin
            if (rep_sel_i == SEL_W'(i) && rise[i]) rep_hit = 1'b1;
        end
    end

    esr_timer #(.TS_W(TS_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick_i),
        .hold_i  (state_q == ST_IDLE),
        .clr_i   (rep_hit),
        .count_o (tmr_cnt)
    );

    // Room for a whole record: two free words.
    assign room   = (level_o <= LVL_W'(DEPTH - 2));
    assign accept = tick_i && (state_q == ST_RUN) && any_rise && room;

    // Remember the level seen at each tick for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n)      prev_q <= '0;
        else if (tick_i) prev_q <= ch_s;
    end

    // Run state, overflow flag and record capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ovf_q   <= 1'b0;
            map_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (start_i) state_q <= ST_RUN;
                ST_HALT: if (start_i) state_q <= ST_RUN;
                default: begin
                    if (tick_i && any_rise) begin
                        if (room) begin
                            map_q <= {ovf_q, rise};
                            ovf_q <= 1'b0;
                        end else begin
                            ovf_q <= 1'b1;
                            if (ovf_halt_i) state_q <= ST_HALT;
                        end
                    end
                end
            endcase
        end
    end

    // Write sequencer: time word, then bitmap word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_NONE;
        end else begin
            case (phase_q)
                PH_TIME: phase_q <= PH_MAP;
                PH_MAP:  phase_q <= PH_NONE;
                default: if (accept) phase_q <= PH_TIME;
            endcase
        end
    end

    // Drive the buffer write port from the sequencer phase.
    always_comb begin
        buf_wr    = (phase_q != PH_NONE);
        buf_wdata = (phase_q == PH_TIME) ? WORD_W'(tmr_cnt) : map_q;
    end

    esr_fifo #(.DEPTH(DEPTH), .W(WORD_W)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (buf_wr),
        .wr_data_i (buf_wdata),
        .rd_en_i   (rd_en_i),
        .rd_data_o (rd_data_o),
        .empty_o   (empty_o),
        .level_o   (level_o)
    );

    assign running_o  = (state_q == ST_RUN);
    assign halted_o   = (state_q == ST_HALT);
    assign ovf_pend_o = ovf_q;

    p_tick_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tick_i |=> (!tick_i ##1 !tick_i))
        else $error("ticks closer than three clocks");

    p_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_TIME) |=> (buf_wr && phase_q == PH_MAP))
        else $error("time word not followed by bitmap word");

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && $past(state_q) == ST_IDLE) |-> !buf_wr)
        else $error("write while idle");

    p_halt_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (halted_o && $past(halted_o)) |-> !buf_wr)
        else $error("write while halted");
endmodule

// File: tb/evt_stamp_rec_bench.sv
// Bench: table-driven edge/bitmap checks, then directed tests for idle,
// timer wrap and both overflow policies.
module evt_stamp_rec_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 8;
    localparam int TS_W       = 8;
    localparam int NVEC       = 10;

    typedef struct packed {
        logic [30:0] ch;
        logic [31:0] map;
    } vec_t;

    // Channel pattern applied on a tick, and the bitmap expected from it.
    localparam vec_t TBL [NVEC] = '{
        '{31'h0000_0000, 32'h0000_0000},
        '{31'h0000_0001, 32'h0000_0001},
        '{31'h0000_0001, 32'h0000_0000},
        '{31'h0000_0000, 32'h0000_0000},
        '{31'h0000_0005, 32'h0000_0005},
        '{31'h0000_0007, 32'h0000_0002},
        '{31'h4000_0000, 32'h4000_0000},
        '{31'h0000_0000, 32'h0000_0000},
        '{31'h2AAA_AAAA, 32'h2AAA_AAAA},
        '{31'h7FFF_FFFF, 32'h5555_5555}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        start = 1'b0;
    logic        ovf_halt = 1'b0;
    logic [4:0]  rep_sel = 5'd31;
    logic [30:0] ch = '0;
    logic        rd_en = 1'b0;
    logic [31:0] rd_data;
    logic        empty;
    logic [3:0]  level;
    logic        running;
    logic        halted;
    logic        ovf_pend;

    int checks = 0;
    int errors = 0;
    int tm = 0;
    int cyc = 0;
    bit done = 0;

    evt_stamp_rec #(.DEPTH(DEPTH), .TS_W(TS_W)) u_evt_stamp_rec (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick),
        .start_i    (start),
        .ovf_halt_i (ovf_halt),
        .rep_sel_i  (rep_sel),
        .ch_i       (ch),
        .rd_en_i    (rd_en),
        .rd_data_o  (rd_data),
        .empty_o    (empty),
        .level_o    (level),
        .running_o  (running),
        .halted_o   (halted),
        .ovf_pend_o (ovf_pend)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Apply a pattern, give the synchronizer time, pulse a tick, let writes land.
    // Updates the time model tm; rep_rise tells whether the selected channel rose.
    task automatic do_tick(input logic [30:0] pat, input bit rep_rise, input bit active);
        ch = pat;
        @(negedge clk);
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        @(negedge clk);
        @(negedge clk);
        if (!active) tm = 0;
        else if (rep_rise) tm = 0;
        else tm = (tm + 1) % 256;
    endtask

    task automatic pop();
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic pulse_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // Event tick on given bits followed by a quiet tick.
    task automatic event_pair(input logic [30:0] pat);
        do_tick(pat, 1'b0, 1'b1);
        do_tick('0, 1'b0, 1'b1);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000 && !done) begin
                errors++;
                checks++;
                $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state: R9, R10
        chk("R9 empty after reset", {31'd0, empty}, 32'd1);
        chk("R9 level after reset", {28'd0, level}, 32'd0);
        chk("R10 idle after reset", {30'd0, running, halted}, 32'd0);

        // R10: edges while idle are not recorded
        do_tick(31'h1, 1'b0, 1'b0);
        do_tick(31'h0, 1'b0, 1'b0);
        chk("R10 no record while idle", {31'd0, empty}, 32'd1);

        // R1: first tick after start stamps 1
        pulse_start();
        chk("R1 running after start", {31'd0, running}, 32'd1);
        do_tick(31'h2, 1'b0, 1'b1);
        chk("R1 first stamp", rd_data, 32'(tm));
        chk("R1 first stamp is one", rd_data, 32'd1);
        pop();
        chk("R4 bitmap after time", rd_data, 32'h2);
        pop();

        // Table walk with repetition channel 30: R3, R4, R5
        rep_sel = 5'd30;
        for (int i = 0; i < NVEC; i++) begin
            do_tick(TBL[i].ch, TBL[i].map[30], 1'b1);
            if (TBL[i].map == 32'd0) begin
                chk($sformatf("R3 no record vec %0d", i), {31'd0, empty}, 32'd1);
            end else begin
                chk($sformatf("R4 level vec %0d", i), {28'd0, level}, 32'd2);
                chk($sformatf("R5 time vec %0d", i), rd_data, 32'(tm));
                pop();
                chk($sformatf("R3 bitmap vec %0d", i), rd_data, TBL[i].map);
                pop();
            end
        end

        // R2: wrap after many quiet ticks
        rep_sel = 5'd31;
        do_tick('0, 1'b0, 1'b1);
        for (int k = 0; k < 260; k++) do_tick('0, 1'b0, 1'b1);
        do_tick(31'h8, 1'b0, 1'b1);
        chk("R2 wrapped stamp", rd_data, 32'(tm));
        pop();
        chk("R2 bitmap", rd_data, 32'h8);
        pop();
        do_tick('0, 1'b0, 1'b1);

        // R5: select 31 disables repetition reset
        do_tick(31'h4000_0000, 1'b0, 1'b1);
        chk("R5 disabled select keeps counting", rd_data, 32'(tm));
        pop();
        pop();
        do_tick('0, 1'b0, 1'b1);

        // R6, R7: auto-resume overflow
        ovf_halt = 1'b0;
        for (int k = 0; k < 4; k++) event_pair(31'h10);
        chk("R6 buffer full", {28'd0, level}, 32'd8);
        do_tick(31'h10, 1'b0, 1'b1);
        chk("R6 record dropped", {28'd0, level}, 32'd8);
        chk("R6 overflow pending", {31'd0, ovf_pend}, 32'd1);
        chk("R7 still running", {31'd0, running}, 32'd1);
        do_tick('0, 1'b0, 1'b1);
        pop();
        pop();
        do_tick(31'h20, 1'b0, 1'b1);
        chk("R6 one word pair added", {28'd0, level}, 32'd8);
        for (int k = 0; k < 6; k++) pop();
        chk("R7 time after overflow", rd_data, 32'(tm));
        pop();
        chk("R7 error bit set", rd_data, 32'h8000_0020);
        pop();
        chk("R7 pending cleared", {31'd0, ovf_pend}, 32'd0);
        do_tick('0, 1'b0, 1'b1);

        // R8: halt-mode overflow
        ovf_halt = 1'b1;
        for (int k = 0; k < 4; k++) event_pair(31'h10);
        do_tick(31'h10, 1'b0, 1'b1);
        chk("R8 halted", {30'd0, halted, running}, 32'd2);
        do_tick('0, 1'b0, 1'b1);
        pop();
        pop();
        do_tick(31'h10, 1'b0, 1'b1);
        chk("R8 no write while halted", {28'd0, level}, 32'd6);
        do_tick('0, 1'b0, 1'b1);
        pulse_start();
        chk("R8 resumed", {30'd0, halted, running}, 32'd1);
        do_tick(31'h40, 1'b0, 1'b1);
        chk("R8 record after resume", {28'd0, level}, 32'd8);
        for (int k = 0; k < 6; k++) pop();
        chk("R8 time after resume", rd_data, 32'(tm));
        pop();
        chk("R8 error bit set", rd_data, 32'h8000_0040);
        pop();
        chk("R9 drained", {31'd0, empty}, 32'd1);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule